// File: doc/BRIEF.md
# Byte-Wide Configuration Loader with Double-Buffered Serializer

This block is the write side of a configuration port that looks to a host like a simple processor peripheral. The host selects the block with a pair of chip selects, places a byte on an 8-bit bus and pulses an active-low write strobe. The byte goes into a hold register. From there it moves into a shift register, which sends it one bit at a time toward configuration storage. Every serial bit is also sent to a daisy-chain output, one clock later, for downstream devices.

The hold and shift registers form a double buffer. A ready flag tells the host whether the hold register can take another byte. The host can poll that flag directly. It can also read it on the top data line by holding write high and pulsing read low while the block is selected. All host strobes are asynchronous to the block clock. They pass through flop synchronizers, and a byte is committed on the rising (deasserting) edge of the write strobe.

A mirror input reverses the bit order of each byte as it is captured. This suits hosts whose data bus is wired in reverse, or whose byte stream is stored in the opposite bit order.

Top module: `cfg_byte_loader`

## Requirements
- R1: The block is selected only while `host_cs_n` is 0 and `host_cs` is 1 together. A write strobe with either select inactive loads nothing, leaves `busy_n` high and produces no serial bits.
- R2: One write strobe yields exactly one byte of eight serial bits. This holds whether the selects are cycled around each byte or held asserted across many bytes.
- R3: If the shift register is empty when a byte is committed, the byte moves into it on the next clock. `busy_n` is then low for exactly one cycle.
- R4: If a byte is committed while the shift register is still sending, `busy_n` stays low until the shift register has sent its last bit. It rises one cycle after that last bit, which is when the held byte moves into the shift register.
- R5: A write committed while `busy_n` is low is dropped and sets `overrun`. `overrun` stays high until reset.
- R6: While the block is selected, write is high and read is low, `host_doe` is 8'h80 and `host_dout[7]` carries `busy_n`. Otherwise `host_doe` is 0. Bits 6 to 0 of `host_doe` are never set.
- R7: With `bit_mirror` at 1, bit i of the captured byte is sent as though it were bit 7-i. With `bit_mirror` at 0, the byte is sent unchanged.
- R8: Serial bits are sent MSB first on `cfg_dout`. Each bit is marked by a one-cycle `cfg_dvalid` pulse, and consecutive bits of a byte are `SHIFT_DIV` cycles apart.
- R9: `chain_clk` and `chain_dout` repeat `cfg_dvalid` and `cfg_dout` exactly, one cycle later.
- R10: After reset, `busy_n` is 1, `overrun` is 0, `cfg_dvalid` and `chain_clk` are 0, and `host_doe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs_n | input | 1 | Active-low chip select (asynchronous) |
| host_cs | input | 1 | Active-high chip select (asynchronous) |
| host_wr_n | input | 1 | Active-low write strobe; a byte is committed on its rising edge |
| host_rd_n | input | 1 | Active-low read strobe for status readback |
| host_din | input | 8 | Host data bus, input side |
| host_dout | output | 8 | Host data bus, output side; only bit 7 carries a value |
| host_doe | output | 8 | Per-bit output enable for the host data bus |
| bit_mirror | input | 1 | 1 = reverse the bit order of each captured byte |
| busy_n | output | 1 | 1 = hold register free, 0 = busy |
| cfg_dout | output | 1 | Serial configuration data |
| cfg_dvalid | output | 1 | One-cycle strobe marking each serial bit |
| chain_dout | output | 1 | Daisy-chain copy of the serial data |
| chain_clk | output | 1 | Daisy-chain copy of the bit strobe |
| overrun | output | 1 | Sticky flag for a write dropped while busy |

## Verification
The hardest case to reach is the long busy interval. To get there, a byte must be committed just after the previous byte has moved into the shift register, and a further write must arrive while the hold register is still full. The bench does this by issuing three writes back to back with the selects held asserted, and it reads status on the data bus between the second and third writes. It then compares the cycle in which `busy_n` rises with the cycle of the first byte's last serial bit, and confirms that the third byte never appears in the stream.

// File: rtl/cfgl_pkg.sv
// Package: types shared by the configuration loader modules.
// Assumes: host strobe polarities are fixed as listed in strobe_t.
package cfgl_pkg;

    // Host strobes as seen after synchronization.
    typedef struct packed {
        logic wr_n;
        logic rd_n;
        logic cs_n;
        logic cs;
    } strobe_t;

    // Idle levels of the strobes, used as the synchronizer reset value.
    localparam logic [3:0] STROBE_IDLE = 4'b1110;

endpackage

// File: rtl/cfgl_sync.sv
// Module: multi-flop synchronizer for a bundle of asynchronous strobes.
// Assumes: every bit is an independent level; STAGES >= 2.
module cfgl_sync #(
    parameter int             WIDTH   = 4,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift each strobe through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d_async;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/cfgl_host_port.sv
// Module: host-side decode. It captures data while write is low and the block
// is selected, commits on the rising edge of write, mirrors the byte on
// request, and drives status onto the top data line during a read.
// Assumes: strobes are already synchronized, and the host holds data stable
// for a few clocks after write rises.
module cfgl_host_port
    import cfgl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           stb,
    input  logic [DATA_W-1:0] data_in,
    input  logic              mirror_en,
    input  logic              ready,
    output logic              wr_commit,
    output logic [DATA_W-1:0] wr_byte,
    output logic [DATA_W-1:0] data_out,
    output logic [DATA_W-1:0] data_oe
);

    logic              sel;
    logic              wr_prev;
    logic              sel_seen;
    logic              wr_rise;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] mirrored;

    assign sel     = !stb.cs_n && stb.cs;
    assign wr_rise = stb.wr_n && !wr_prev;

    // Remember the previous write level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_prev <= 1'b1;
        else        wr_prev <= stb.wr_n;
    end

    // Track data and selection while the write strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            sel_seen <= 1'b0;
        end else if (!stb.wr_n && sel) begin
            data_q   <= data_in;
            sel_seen <= 1'b1;
        end else if (wr_rise) begin
            sel_seen <= 1'b0;
        end
    end

    // Bit-reversed copy of the captured byte.
    genvar i;
    generate
        for (i = 0; i < DATA_W; i++) begin : g_mirror
            assign mirrored[i] = data_q[DATA_W-1-i];
        end
    endgenerate

    assign wr_commit = wr_rise && sel_seen;
    assign wr_byte   = mirror_en ? mirrored : data_q;

    // Status readback: only the top line is ever enabled.
    always_comb begin
        data_out = {ready, {(DATA_W-1){1'b0}}};
        data_oe  = {(sel && stb.wr_n && !stb.rd_n), {(DATA_W-1){1'b0}}};
    end

endmodule

// File: rtl/cfgl_shift_buffer.sv
// Module: hold register plus shift register. It sends MSB first, one bit
// every SHIFT_DIV clocks, repeats each bit onto the daisy-chain outputs one
// cycle later, and flags writes that arrive while the hold register is full.
// Assumes: SHIFT_DIV >= 2, so bit strobes never fall on adjacent cycles.
module cfgl_shift_buffer #(
    parameter int DATA_W    = 8,
    parameter int SHIFT_DIV = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_commit,
    input  logic [DATA_W-1:0]          wr_byte,
    output logic                       ready,
    output logic                       hold_full,
    output logic [$clog2(DATA_W+1)-1:0] bits_left,
    output logic                       ser_data,
    output logic                       ser_valid,
    output logic                       dchain_data,
    output logic                       dchain_clk,
    output logic                       overrun
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int DIV_W = (SHIFT_DIV > 1) ? $clog2(SHIFT_DIV) : 1;

    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] shift_q;
    logic [DIV_W-1:0]  div_q;
    logic              load;

    assign load  = hold_full && (bits_left == '0);
    assign ready = !hold_full;

    // Hold register: accept a byte when free, release it to the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (wr_commit && !hold_full) begin
            hold_q    <= wr_byte;
            hold_full <= 1'b1;
        end else if (load) begin
            hold_full <= 1'b0;
        end
    end

    // Sticky flag for a write that found the hold register full.
    always_ff @(posedge clk) begin
        if (!rst_n)                     overrun <= 1'b0;
        else if (wr_commit && hold_full) overrun <= 1'b1;
    end

    // Shift register with bit-rate divider and registered serial outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q   <= '0;
            bits_left <= '0;
            div_q     <= '0;
            ser_data  <= 1'b0;
            ser_valid <= 1'b0;
        end else begin
            ser_valid <= 1'b0;
            if (load) begin
                shift_q   <= hold_q;
                bits_left <= CNT_W'(DATA_W);
                div_q     <= '0;
            end else if (bits_left != '0) begin
                if (div_q == DIV_W'(SHIFT_DIV - 1)) begin
                    ser_data  <= shift_q[DATA_W-1];
                    ser_valid <= 1'b1;
                    shift_q   <= {shift_q[DATA_W-2:0], 1'b0};
                    bits_left <= bits_left - 1'b1;
                    div_q     <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    // Daisy-chain repeater, one cycle behind the serial stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dchain_data <= 1'b0;
            dchain_clk  <= 1'b0;
        end else begin
            dchain_data <= ser_data;
            dchain_clk  <= ser_valid;
        end
    end

endmodule

// File: rtl/cfg_byte_loader.sv
// Module: top of the byte-wide configuration loader. It synchronizes the host
// strobes, decodes writes and status reads, and feeds the double-buffered
// serializer.
// Assumes: the host waits for busy_n high before each write, or accepts
// that a write made while busy_n is low is dropped and flagged.
module cfg_byte_loader
    import cfgl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SHIFT_DIV   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs_n,
    input  logic              host_cs,
    input  logic              host_wr_n,
    input  logic              host_rd_n,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic [DATA_W-1:0] host_doe,
    input  logic              bit_mirror,
    output logic              busy_n,
    output logic              cfg_dout,
    output logic              cfg_dvalid,
    output logic              chain_dout,
    output logic              chain_clk,
    output logic              overrun
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int STB_W = $bits(strobe_t);

    strobe_t           stb_raw;
    strobe_t           stb_s;
    logic              wr_commit;
    logic [DATA_W-1:0] wr_byte;
    logic              hold_full;
    logic [CNT_W-1:0]  bits_left;

    assign stb_raw = '{wr_n: host_wr_n, rd_n: host_rd_n, cs_n: host_cs_n, cs: host_cs};

    cfgl_sync #(
        .WIDTH  (STB_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(STROBE_IDLE)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(stb_raw),
        .q      (stb_s)
    );

    cfgl_host_port #(
        .DATA_W(DATA_W)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (stb_s),
        .data_in  (host_din),
        .mirror_en(bit_mirror),
        .ready    (busy_n),
        .wr_commit(wr_commit),
        .wr_byte  (wr_byte),
        .data_out (host_dout),
        .data_oe  (host_doe)
    );

    cfgl_shift_buffer #(
        .DATA_W   (DATA_W),
        .SHIFT_DIV(SHIFT_DIV)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_commit  (wr_commit),
        .wr_byte    (wr_byte),
        .ready      (busy_n),
        .hold_full  (hold_full),
        .bits_left  (bits_left),
        .ser_data   (cfg_dout),
        .ser_valid  (cfg_dvalid),
        .dchain_data(chain_dout),
        .dchain_clk (chain_clk),
        .overrun    (overrun)
    );

endmodule

// File: rtl/cfgl_checker.sv
// Module: assertion checker for cfg_byte_loader, attached by bind.
// Assumes: SHIFT_DIV >= 2.
module cfgl_checker #(
    parameter int DATA_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        ready,
    input logic                        hold_full,
    input logic [$clog2(DATA_W+1)-1:0] bits_left,
    input logic                        ser_data,
    input logic                        ser_valid,
    input logic                        dchain_data,
    input logic                        dchain_clk,
    input logic                        overrun,
    input logic [DATA_W-1:0]           data_out,
    input logic [DATA_W-1:0]           data_oe
);

    // R3: a full hold register with an idle shifter is released next cycle.
    assert_quick_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && bits_left == '0) |=> !hold_full);

    // R4: ready returns only when the shifter has just taken a whole byte.
    assert_ready_after_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (bits_left == ($clog2(DATA_W+1))'(DATA_W)));

    // R5: overrun never clears outside reset.
    assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R6: an enabled top line carries the ready flag.
    assert_status_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe[DATA_W-1] |-> (data_out[DATA_W-1] == ready));

    // R8: bit strobes are single-cycle pulses.
    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |=> !ser_valid);

    // R9: daisy-chain repeats each bit one cycle later.
    assert_chain_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |=> (dchain_clk && dchain_data == $past(ser_data)));

    // R9: no daisy-chain clock without a preceding serial bit.
    assert_chain_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid |=> !dchain_clk);

endmodule

bind cfg_byte_loader cfgl_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (busy_n),
    .hold_full  (hold_full),
    .bits_left  (bits_left),
    .ser_data   (cfg_dout),
    .ser_valid  (cfg_dvalid),
    .dchain_data(chain_dout),
    .dchain_clk (chain_clk),
    .overrun    (overrun),
    .data_out   (host_dout),
    .data_oe    (host_doe)
);

// File: tb/sim_cfg_byte_loader.sv
module sim_cfg_byte_loader;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs_n = 1'b1;
    logic       host_cs = 1'b0;
    logic       host_wr_n = 1'b1;
    logic       host_rd_n = 1'b1;
    logic [7:0] host_din = 8'h00;
    logic [7:0] host_dout;
    logic [7:0] host_doe;
    logic       bit_mirror = 1'b0;
    logic       busy_n;
    logic       cfg_dout;
    logic       cfg_dvalid;
    logic       chain_dout;
    logic       chain_clk;
    logic       overrun;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cfg_byte_loader #(.DATA_W(8), .SHIFT_DIV(DIV), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_cs(host_cs),
        .host_wr_n(host_wr_n), .host_rd_n(host_rd_n), .host_din(host_din),
        .host_dout(host_dout), .host_doe(host_doe), .bit_mirror(bit_mirror),
        .busy_n(busy_n), .cfg_dout(cfg_dout), .cfg_dvalid(cfg_dvalid),
        .chain_dout(chain_dout), .chain_clk(chain_clk), .overrun(overrun)
    );

    // Monitor state, sampled at the falling edge.
    int         cyc = 0;
    int         rx_cnt = 0;
    int         last_bit_cyc = 0;
    int         space_err = 0;
    int         chain_err = 0;
    int         fall_cnt = 0;
    int         run = 0;
    int         last_busy_len = 0;
    int         rise_cyc = 0;
    logic [7:0] rx_sh = 8'h00;
    logic [7:0] rx_bytes [64];
    int         byte_end [64];
    logic       prev_ready = 1'b1;
    logic       prev_valid = 1'b0;
    logic       prev_data = 1'b0;

    always @(negedge clk) begin
        logic [7:0] nsh;
        cyc++;
        if (rst_n) begin
            if (chain_clk != prev_valid || (prev_valid && chain_dout != prev_data))
                chain_err++;
            if (cfg_dvalid) begin
                if ((rx_cnt % 8) != 0 && (cyc - last_bit_cyc) != DIV) space_err++;
                last_bit_cyc = cyc;
                nsh = {rx_sh[6:0], cfg_dout};
                rx_sh = nsh;
                if ((rx_cnt % 8) == 7 && rx_cnt / 8 < 64) begin
                    rx_bytes[rx_cnt/8] = nsh;
                    byte_end[rx_cnt/8] = cyc;
                end
                rx_cnt++;
            end
            if (!busy_n) begin
                if (prev_ready) fall_cnt++;
                run++;
            end else begin
                if (!prev_ready) begin
                    last_busy_len = run;
                    rise_cyc = cyc;
                end
                run = 0;
            end
            prev_ready = busy_n;
        end else begin
            prev_ready = 1'b1;
            run = 0;
        end
        prev_valid = cfg_dvalid;
        prev_data = cfg_dout;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int actual, input int expected);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    // One write strobe with the given select levels; optionally release selects after.
    task automatic write_byte(input logic [7:0] b, input logic csn, input logic csv, input bit release_cs);
        host_cs_n = csn;
        host_cs = csv;
        host_din = b;
        tick();
        host_wr_n = 1'b0;
        repeat (3) tick();
        host_wr_n = 1'b1;
        repeat (4) tick();
        if (release_cs) begin
            host_cs_n = 1'b1;
            host_cs = 1'b0;
        end
    endtask

    task automatic wait_bits(input int n);
        for (int k = 0; k < 2000 && rx_cnt < n; k++) tick();
    endtask

    // {mirror, host byte, expected serial byte}
    localparam logic [16:0] VEC [6] = '{
        {1'b0, 8'hA5, 8'hA5},
        {1'b1, 8'h01, 8'h80},
        {1'b1, 8'hC4, 8'h23},
        {1'b0, 8'h00, 8'h00},
        {1'b0, 8'hFF, 8'hFF},
        {1'b1, 8'h0F, 8'hF0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int base;
        int nfall;
        int idx_a;
        repeat (3) tick();
        // R10: state held in reset
        check(busy_n == 1'b1, "R10 busy_n", busy_n, 1);
        check(overrun == 1'b0, "R10 overrun", overrun, 0);
        check(cfg_dvalid == 1'b0 && chain_clk == 1'b0, "R10 strobes", {cfg_dvalid, chain_clk}, 0);
        check(host_doe == 8'h00, "R10 doe", host_doe, 0);
        rst_n = 1'b1;
        repeat (3) tick();

        // Table walk: R2 R3 R7 R8 R9, selects cycled or held per entry
        for (int i = 0; i < 6; i++) begin
            bit keep;
            keep = (i % 2) == 1;
            bit_mirror = VEC[i][16];
            base = rx_cnt;
            write_byte(VEC[i][15:8], 1'b0, 1'b1, !keep);
            wait_bits(base + 8);
            repeat (3 * DIV) tick();
            check(rx_cnt == base + 8, "R2 one byte per strobe", rx_cnt - base, 8);
            check(rx_bytes[base/8] == VEC[i][7:0], "R7/R8 serial byte", rx_bytes[base/8], VEC[i][7:0]);
            check(last_busy_len == 1, "R3 short busy", last_busy_len, 1);
        end
        check(space_err == 0, "R8 bit spacing", space_err, 0);
        check(chain_err == 0, "R9 daisy copy", chain_err, 0);
        bit_mirror = 1'b0;
        host_cs_n = 1'b1;
        host_cs = 1'b0;
        repeat (4) tick();

        // R1: writes with one select inactive are ignored
        base = rx_cnt;
        nfall = fall_cnt;
        write_byte(8'h3C, 1'b1, 1'b1, 1'b1);
        write_byte(8'h3C, 1'b0, 1'b0, 1'b1);
        repeat (40) tick();
        check(rx_cnt == base, "R1 no bits when deselected", rx_cnt - base, 0);
        check(fall_cnt == nfall, "R1 busy_n untouched", fall_cnt - nfall, 0);

        // R6: status readback on the top line only
        host_cs_n = 1'b0;
        host_cs = 1'b1;
        host_rd_n = 1'b0;
        repeat (4) tick();
        check(host_doe == 8'h80, "R6 doe when reading", host_doe, 8'h80);
        check(host_dout[7] == 1'b1, "R6 ready on D7", host_dout[7], 1);
        host_cs_n = 1'b1;
        repeat (4) tick();
        check(host_doe == 8'h00, "R6 doe when deselected", host_doe, 0);
        host_rd_n = 1'b1;
        repeat (4) tick();

        // R4/R5: long busy and dropped write, selects held
        base = rx_cnt;
        idx_a = base / 8;
        write_byte(8'h96, 1'b0, 1'b1, 1'b0);
        write_byte(8'h5A, 1'b0, 1'b1, 1'b0);
        host_rd_n = 1'b0;
        repeat (4) tick();
        check(host_doe == 8'h80 && host_dout[7] == 1'b0, "R6 busy on D7", {host_doe, host_dout[7]}, {8'h80, 1'b0});
        host_rd_n = 1'b1;
        repeat (3) tick();
        write_byte(8'hE1, 1'b0, 1'b1, 1'b0);
        check(overrun == 1'b1, "R5 overrun set", overrun, 1);
        wait_bits(base + 16);
        repeat (40 * DIV) tick();
        check(rx_cnt == base + 16, "R5 dropped byte absent", rx_cnt - base, 16);
        check(rx_bytes[idx_a] == 8'h96, "R4 first byte", rx_bytes[idx_a], 8'h96);
        check(rx_bytes[idx_a+1] == 8'h5A, "R4 second byte", rx_bytes[idx_a+1], 8'h5A);
        check(rise_cyc == byte_end[idx_a] + 1, "R4 ready after last bit", rise_cyc, byte_end[idx_a] + 1);
        check(last_busy_len > DIV, "R4 long busy", last_busy_len, 6 * DIV);
        check(overrun == 1'b1, "R5 overrun sticky", overrun, 1);
        check(space_err == 0 && chain_err == 0, "R8/R9 stream", space_err + chain_err, 0);

        // R10: reset clears overrun
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        tick();
        check(overrun == 1'b0, "R10 overrun after reset", overrun, 0);
        check(busy_n == 1'b1, "R10 busy_n after reset", busy_n, 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule